// File: doc/BRIEF.md
# Ethernet PHY Management Register Model

This block stands in for one Ethernet PHY on the management path of a MAC. Software writes a 32-bit management frame word through a register bus. The block splits that word into an operation bit, a PHY address, a register number and 16 data bits. A read puts the PHY register contents into the low half of the frame register. A write updates the PHY state that the block models: control, status, advertisement, interrupt source and interrupt mask.

A link input feeds the status bits and latches link events into the interrupt source. Every frame write produces a one-cycle completion pulse for the MAC's interrupt logic. A level PHY interrupt is driven from the unmasked interrupt sources. Pin-level serial timing, vendor-specific registers and real auto-negotiation are not part of this block.

Top module: `mdio_phy_model`

## Requirements
- R1: A frame write stores the word in the frame register one cycle later. Bit 29 = 1 marks a read and bit 29 = 0 marks a write. Bits 27..23 hold the PHY address, bits 22..18 the register number and bits 15..0 the data. A write keeps the whole word. A read keeps bits 31..16 and replaces bits 15..0 with the register data.
- R2: `mgmt_done` is high for exactly the one cycle after each frame write, whether it is a read or a write, and is low at all other times.
- R3: If the PHY address differs from parameter `PHY_NUM`, a read returns 0xFFFF and a write changes nothing.
- R4: After reset, control is 0x3000, advertisement is 0x01E1, and interrupt mask and interrupt source are 0. Status is 0x7809, and the current link state is then applied to it once.
- R5: Register 2 reads 0x0007, register 3 reads 0xC0D1, register 5 reads 0x0F71 and register 6 reads 0x0001. Any register without a listed function reads 0, and writes to it have no effect.
- R6: A write to register 0 with bit 15 clear sets control to the data AND 0x7980. If data bit 12 is set, the write also sets status bit 5.
- R7: A write to register 0 with bit 15 set restores the full reset image of R4, including the link refresh.
- R8: A write to register 4 stores (data AND 0x2D7F) OR 0x0080.
- R9: A write to register 30 stores data bits 7..0 as the interrupt mask. A read of register 30 returns the mask, zero-extended.
- R10: A read of register 29 returns the interrupt source and clears it.
- R11: When the link goes up, status bits 5 and 2 are set and interrupt source bits 7 and 6 are set. When the link goes down, status bits 5 and 2 are cleared and interrupt source bit 4 is set.
- R12: `phy_irq` is high exactly while (interrupt source AND interrupt mask) is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| frame_wr | input | 1 | Write strobe for the management frame register |
| frame_wdata | input | 32 | Frame word being written |
| frame_rdata | output | 32 | Current contents of the frame register |
| link_up | input | 1 | Link state, 1 = up |
| mgmt_done | output | 1 | One-cycle pulse marking a completed management transfer |
| phy_irq | output | 1 | Level interrupt from the unmasked PHY interrupt sources |

## Verification
The bench builds the block with `PHY_NUM` = 5 rather than the default of 0. This makes it easy to tell a matching PHY address from a mismatching one: the bench uses address 3 for the mismatch cases, so both the ignored-write path and the 0xFFFF read path are driven with nonzero address bits. The single PHY address field is 5 bits wide, so with this value every frame the bench sends exercises nonzero, non-all-ones address bits through the compare.

// File: rtl/mdio_phy_pkg.sv
package mdio_phy_pkg;
  localparam int FRAME_W  = 32;
  localparam int DATA_W   = 16;
  localparam int OP_BIT   = 29;
  localparam int FIELD_LO = 18;
  localparam int FIELD_W  = 10;
  localparam int REG_W    = 5;
  localparam int PHY_W    = FIELD_W - REG_W;
  localparam int INT_W    = 8;

  localparam logic [DATA_W-1:0] CTRL_RST    = 16'h3000;
  localparam logic [DATA_W-1:0] STAT_RST    = 16'h7809;
  localparam logic [DATA_W-1:0] ADV_RST     = 16'h01E1;
  localparam logic [DATA_W-1:0] ID_HI       = 16'h0007;
  localparam logic [DATA_W-1:0] ID_LO       = 16'hC0D1;
  localparam logic [DATA_W-1:0] PARTNER_VAL = 16'h0F71;
  localparam logic [DATA_W-1:0] EXPAN_VAL   = 16'h0001;
  localparam logic [DATA_W-1:0] CTRL_WMASK  = 16'h7980;
  localparam logic [DATA_W-1:0] ADV_WMASK   = 16'h2D7F;
  localparam logic [DATA_W-1:0] ADV_FORCE   = 16'h0080;
  localparam logic [DATA_W-1:0] LINK_STAT   = 16'h0024;
  localparam logic [DATA_W-1:0] ANEG_STAT   = 16'h0020;
  localparam logic [INT_W-1:0]  INT_UP      = 8'hC0;
  localparam logic [INT_W-1:0]  INT_DOWN    = 8'h10;

  localparam logic [REG_W-1:0] RG_CTRL = 5'd0;
  localparam logic [REG_W-1:0] RG_STAT = 5'd1;
  localparam logic [REG_W-1:0] RG_IDH  = 5'd2;
  localparam logic [REG_W-1:0] RG_IDL  = 5'd3;
  localparam logic [REG_W-1:0] RG_ADV  = 5'd4;
  localparam logic [REG_W-1:0] RG_LPA  = 5'd5;
  localparam logic [REG_W-1:0] RG_EXP  = 5'd6;
  localparam logic [REG_W-1:0] RG_ISRC = 5'd29;
  localparam logic [REG_W-1:0] RG_IMSK = 5'd30;

  typedef struct packed {
    logic              rd;
    logic              hit;
    logic [REG_W-1:0]  idx;
    logic [DATA_W-1:0] data;
  } mgmt_req_t;
endpackage

// File: rtl/mdio_rst_sync.sv
module mdio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/mdio_frame_decode.sv
module mdio_frame_decode
  import mdio_phy_pkg::*;
#(
  parameter int unsigned PHY_NUM = 0
) (
  input  logic               op_bit,
  input  logic [FIELD_W-1:0] field,
  input  logic [DATA_W-1:0]  data,
  output mgmt_req_t          req
);
  localparam logic [PHY_W-1:0] PHY_SEL = PHY_W'(PHY_NUM);

  always_comb begin
    req.rd   = op_bit;
    req.hit  = (field[FIELD_W-1:REG_W] == PHY_SEL);
    req.idx  = field[REG_W-1:0];
    req.data = data;
  end
endmodule

// File: rtl/mdio_link_monitor.sv
module mdio_link_monitor (
  input  logic clk,
  input  logic rst_n,
  input  logic link_up,
  input  logic refresh_req,
  output logic link_evt
);
  logic prev_q, prev_d;
  logic pend_q, pend_d;

  always_comb begin
    prev_d   = link_up;
    pend_d   = refresh_req;
    link_evt = pend_q | (link_up != prev_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b1;
    end else begin
      prev_q <= prev_d;
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/mdio_phy_regs.sv
module mdio_phy_regs
  import mdio_phy_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              access,
  input  mgmt_req_t         req,
  input  logic              link_evt,
  input  logic              link_up,
  output logic [DATA_W-1:0] rdata,
  output logic              soft_rst,
  output logic              irq
);
  logic [DATA_W-1:0] ctrl_q, ctrl_d, stat_q, stat_d, adv_q, adv_d;
  logic [INT_W-1:0]  isrc_q, isrc_d, imsk_q, imsk_d;
  logic              wr_en, rd_en;

  assign wr_en = access & req.hit & ~req.rd;
  assign rd_en = access & req.hit &  req.rd;

  always_comb begin
    ctrl_d   = ctrl_q;
    stat_d   = stat_q;
    adv_d    = adv_q;
    isrc_d   = isrc_q;
    imsk_d   = imsk_q;
    soft_rst = 1'b0;
    if (wr_en) begin
      unique case (req.idx)
        RG_CTRL: begin
          if (req.data[15]) begin
            soft_rst = 1'b1;
            ctrl_d   = CTRL_RST;
            stat_d   = STAT_RST;
            adv_d    = ADV_RST;
            isrc_d   = '0;
            imsk_d   = '0;
          end else begin
            ctrl_d = req.data & CTRL_WMASK;
            if (req.data[12]) stat_d = stat_q | ANEG_STAT;
          end
        end
        RG_ADV:  adv_d  = (req.data & ADV_WMASK) | ADV_FORCE;
        RG_IMSK: imsk_d = req.data[INT_W-1:0];
        default: ;
      endcase
    end
    if (rd_en && req.idx == RG_ISRC) isrc_d = '0;
    if (link_evt) begin
      if (link_up) begin
        stat_d = stat_d | LINK_STAT;
        isrc_d = isrc_d | INT_UP;
      end else begin
        stat_d = stat_d & ~LINK_STAT;
        isrc_d = isrc_d | INT_DOWN;
      end
    end
  end

  always_comb begin
    if (!req.hit) rdata = '1;
    else begin
      unique case (req.idx)
        RG_CTRL: rdata = ctrl_q;
        RG_STAT: rdata = stat_q;
        RG_IDH:  rdata = ID_HI;
        RG_IDL:  rdata = ID_LO;
        RG_ADV:  rdata = adv_q;
        RG_LPA:  rdata = PARTNER_VAL;
        RG_EXP:  rdata = EXPAN_VAL;
        RG_ISRC: rdata = {{(DATA_W-INT_W){1'b0}}, isrc_q};
        RG_IMSK: rdata = {{(DATA_W-INT_W){1'b0}}, imsk_q};
        default: rdata = '0;
      endcase
    end
  end

  assign irq = |(isrc_q & imsk_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      stat_q <= STAT_RST;
      adv_q  <= ADV_RST;
      isrc_q <= '0;
      imsk_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      stat_q <= stat_d;
      adv_q  <= adv_d;
      isrc_q <= isrc_d;
      imsk_q <= imsk_d;
    end
  end
endmodule

// File: rtl/mdio_phy_model.sv
module mdio_phy_model
  import mdio_phy_pkg::*;
#(
  parameter int unsigned PHY_NUM = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_wr,
  input  logic [FRAME_W-1:0] frame_wdata,
  output logic [FRAME_W-1:0] frame_rdata,
  input  logic               link_up,
  output logic               mgmt_done,
  output logic               phy_irq
);
  logic              rst_sync_n;
  mgmt_req_t         req;
  logic              link_evt, soft_rst;
  logic [DATA_W-1:0] reg_rdata;
  logic [FRAME_W-1:0] frame_q, frame_d;
  logic              done_q, done_d;

  mdio_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  mdio_frame_decode #(.PHY_NUM(PHY_NUM)) u_dec (
    .op_bit(frame_wdata[OP_BIT]),
    .field (frame_wdata[FIELD_LO+FIELD_W-1:FIELD_LO]),
    .data  (frame_wdata[DATA_W-1:0]),
    .req   (req)
  );

  mdio_link_monitor u_link (
    .clk(clk), .rst_n(rst_sync_n), .link_up(link_up),
    .refresh_req(soft_rst), .link_evt(link_evt)
  );

  mdio_phy_regs u_regs (
    .clk(clk), .rst_n(rst_sync_n), .access(frame_wr), .req(req),
    .link_evt(link_evt), .link_up(link_up), .rdata(reg_rdata),
    .soft_rst(soft_rst), .irq(phy_irq)
  );

  always_comb begin
    frame_d = frame_q;
    done_d  = frame_wr;
    if (frame_wr) begin
      if (req.rd) frame_d = {frame_wdata[FRAME_W-1:DATA_W], reg_rdata};
      else        frame_d = frame_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      frame_q <= '0;
      done_q  <= 1'b0;
    end else begin
      frame_q <= frame_d;
      done_q  <= done_d;
    end
  end

  assign frame_rdata = frame_q;
  assign mgmt_done   = done_q;
endmodule

// File: rtl/mdio_phy_model_chk.sv
module mdio_phy_model_chk
  import mdio_phy_pkg::*;
#(
  parameter int unsigned PHY_NUM = 0
) (
  input logic               clk,
  input logic               rst_n,
  input logic               frame_wr,
  input logic [FRAME_W-1:0] frame_wdata,
  input logic [FRAME_W-1:0] frame_rdata,
  input logic               mgmt_done,
  input logic               phy_irq
);
  localparam logic [PHY_W-1:0] PHY_SEL = PHY_W'(PHY_NUM);

  logic             c_rd, c_hit;
  logic [REG_W-1:0] c_idx;
  assign c_rd  = frame_wdata[OP_BIT];
  assign c_hit = frame_wdata[FIELD_LO+FIELD_W-1:FIELD_LO+REG_W] == PHY_SEL;
  assign c_idx = frame_wdata[FIELD_LO+REG_W-1:FIELD_LO];

  // R2
  p_done_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_wr |=> mgmt_done);
  p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_wr |=> !mgmt_done);
  // R1
  p_write_echo_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_wr && !c_rd) |=> frame_rdata == $past(frame_wdata));
  p_read_upper_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_wr && c_rd) |=> frame_rdata[FRAME_W-1:DATA_W] == $past(frame_wdata[FRAME_W-1:DATA_W]));
  // R3
  p_miss_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_wr && c_rd && !c_hit) |=> frame_rdata[DATA_W-1:0] == 16'hFFFF);
  // R5
  p_id_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_wr && c_rd && c_hit && c_idx == RG_IDH) |=> frame_rdata[DATA_W-1:0] == ID_HI);
  // R12
  p_mask_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_wr && !c_rd && c_hit && c_idx == RG_IMSK && frame_wdata[INT_W-1:0] == '0) |=> !phy_irq);
endmodule

bind mdio_phy_model mdio_phy_model_chk #(.PHY_NUM(PHY_NUM)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .frame_wr(frame_wr), .frame_wdata(frame_wdata),
  .frame_rdata(frame_rdata), .mgmt_done(mgmt_done), .phy_irq(phy_irq)
);

// File: tb/mdio_phy_model_tb_top.sv
module mdio_phy_model_tb_top;
  localparam int unsigned PHY = 5;
  localparam int NVEC = 24;

  logic        clk, rst_n, frame_wr, link_up;
  logic [31:0] frame_wdata, frame_rdata;
  logic        mgmt_done, phy_irq;
  int          checks = 0, errors = 0;
  bit          finished = 0;

  mdio_phy_model #(.PHY_NUM(PHY)) dut_i (
    .clk(clk), .rst_n(rst_n), .frame_wr(frame_wr), .frame_wdata(frame_wdata),
    .frame_rdata(frame_rdata), .link_up(link_up), .mgmt_done(mgmt_done), .phy_irq(phy_irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {rd, phy, reg, data, expected low half}
  localparam logic [42:0] VEC [NVEC] = '{
    {1'b1, 5'd5, 5'd0,  16'h0000, 16'h3000},   // R4
    {1'b1, 5'd5, 5'd1,  16'h0000, 16'h782D},   // R4 R11
    {1'b1, 5'd5, 5'd2,  16'h0000, 16'h0007},   // R5
    {1'b1, 5'd5, 5'd3,  16'h0000, 16'hC0D1},   // R5
    {1'b1, 5'd5, 5'd4,  16'h0000, 16'h01E1},   // R4
    {1'b1, 5'd5, 5'd5,  16'h0000, 16'h0F71},   // R5
    {1'b1, 5'd5, 5'd6,  16'h0000, 16'h0001},   // R5
    {1'b1, 5'd5, 5'd7,  16'h0000, 16'h0000},   // R5
    {1'b1, 5'd5, 5'd30, 16'h0000, 16'h0000},   // R4
    {1'b1, 5'd5, 5'd29, 16'h0000, 16'h00C0},   // R10 R11
    {1'b1, 5'd5, 5'd29, 16'h0000, 16'h0000},   // R10
    {1'b0, 5'd5, 5'd4,  16'hFFFF, 16'hFFFF},   // R1
    {1'b1, 5'd5, 5'd4,  16'h0000, 16'h2DFF},   // R8
    {1'b0, 5'd5, 5'd4,  16'h0000, 16'h0000},   // R1
    {1'b1, 5'd5, 5'd4,  16'h0000, 16'h0080},   // R8
    {1'b0, 5'd5, 5'd0,  16'h1100, 16'h1100},   // R1
    {1'b1, 5'd5, 5'd0,  16'h0000, 16'h1100},   // R6
    {1'b0, 5'd5, 5'd30, 16'h1234, 16'h1234},   // R1
    {1'b1, 5'd5, 5'd30, 16'h0000, 16'h0034},   // R9
    {1'b1, 5'd3, 5'd0,  16'h0000, 16'hFFFF},   // R3
    {1'b0, 5'd3, 5'd4,  16'hFFFF, 16'hFFFF},   // R3
    {1'b1, 5'd5, 5'd4,  16'h0000, 16'h0080},   // R3
    {1'b0, 5'd5, 5'd7,  16'hFFFF, 16'hFFFF},   // R5
    {1'b1, 5'd5, 5'd7,  16'h0000, 16'h0000}    // R5
  };

  function automatic logic [31:0] mk(input logic rd, input logic [4:0] phy,
                                     input logic [4:0] rg, input logic [15:0] d);
    return {2'b01, rd, ~rd, phy, rg, 2'b10, d};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic rd, input logic [4:0] phy, input logic [4:0] rg,
                      input logic [15:0] d);
    @(negedge clk);
    frame_wr    = 1'b1;
    frame_wdata = mk(rd, phy, rg, d);
    @(negedge clk);
    frame_wr    = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [4:0] rg, input logic [15:0] exp);
    xfer(1'b1, 5'd5, rg, 16'h0);
    chk(req, frame_rdata, {mk(1'b1, 5'd5, rg, 16'h0) >> 16, exp});
  endtask

  initial begin
    rst_n = 1'b0; frame_wr = 1'b0; frame_wdata = '0; link_up = 1'b1;
    repeat (3) @(negedge clk);
    chk("R4 reset frame", frame_rdata, 32'h0);
    chk("R2 reset done", {31'h0, mgmt_done}, 32'h0);
    chk("R12 reset irq", {31'h0, phy_irq}, 32'h0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      logic [42:0] v;
      logic [31:0] w, e;
      v = VEC[i];
      w = mk(v[42], v[41:37], v[36:32], v[31:16]);
      xfer(v[42], v[41:37], v[36:32], v[31:16]);
      e = v[42] ? {w[31:16], v[15:0]} : w;
      chk($sformatf("R1 vector %0d", i), frame_rdata, e);
      chk($sformatf("R2 vector %0d done", i), {31'h0, mgmt_done}, 32'h1);
    end
    @(negedge clk);
    chk("R2 idle done low", {31'h0, mgmt_done}, 32'h0);

    // R11 link down, R12 with mask 0x34
    link_up = 1'b0;
    @(negedge clk);
    chk("R12 irq on link down", {31'h0, phy_irq}, 32'h1);
    rd_chk("R11 status down", 5'd1, 16'h7809);
    rd_chk("R10 source down", 5'd29, 16'h0010);
    chk("R12 irq cleared", {31'h0, phy_irq}, 32'h0);

    // R6 bit 12 sets status bit 5
    xfer(1'b0, 5'd5, 5'd0, 16'h1000);
    rd_chk("R6 control", 5'd0, 16'h1000);
    rd_chk("R6 status bit5", 5'd1, 16'h7829);

    // R7 soft reset
    xfer(1'b0, 5'd5, 5'd0, 16'h8000);
    @(negedge clk);
    rd_chk("R7 control", 5'd0, 16'h3000);
    rd_chk("R7 status", 5'd1, 16'h7809);
    rd_chk("R7 adv", 5'd4, 16'h01E1);
    rd_chk("R7 mask", 5'd30, 16'h0000);
    rd_chk("R7 source refresh", 5'd29, 16'h0010);

    // R11 link up, R12 masking
    link_up = 1'b1;
    @(negedge clk);
    chk("R12 irq masked", {31'h0, phy_irq}, 32'h0);
    xfer(1'b0, 5'd5, 5'd30, 16'h0080);
    chk("R12 irq unmasked", {31'h0, phy_irq}, 32'h1);
    xfer(1'b0, 5'd5, 5'd30, 16'h0010);
    chk("R12 irq other bit", {31'h0, phy_irq}, 32'h0);
    rd_chk("R11 status up", 5'd1, 16'h782D);
    rd_chk("R11 source up", 5'd29, 16'h00C0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule